// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers the violation level lines raised by a set of peripheral protection controllers, memory protection controllers and expansion memory security checkers. It presents them as status words on a 32-bit secure register port. Software can read these words, mask them and clear them through that port. Every protection controller gets its own enable line and its own clear line back. Every expansion checker gets a clear line and a non-secure configuration line. All checker violations are merged into one interrupt, which is gated by an enable word.

The controller status bits sit at sparse, fixed positions, because each position is hard-wired to one controller:

| Controller | Status bits |
|------------|-------------|
| Internal APB controllers 0 and 1 | 0 and 1 |
| APB expansion controllers 0 to 3 | 4 to 7 |
| AHB expansion controllers 0 to 3 | 20 to 23 |

Checker and expansion-MPC status sits in the upper half-word of its register. Every status register is refreshed from its input lines on each clock, so it follows the level and does not latch it. The sources decide when a violation is raised. This block only aggregates the lines and routes control back.

Register access is one word per cycle. A write is taken on the clock edge while `reg_wr` is high. Read data is a combinational function of `reg_addr`. The offsets are fixed:

| Offset | Content |
|--------|---------|
| 0x1C | MPC status |
| 0x20 | Controller status |
| 0x24 | Controller clear |
| 0x28 | Controller enable |
| 0x30 | Checker status |
| 0x34 | Checker clear |
| 0x38 | Checker enable |
| 0x40 | Bridge status |
| 0x44 | Bridge clear |
| 0x48 | Bridge enable |
| 0xD0 | Checker non-secure |

Top module: `sec_irq_hub`

## Requirements
- R1: The controller status word at 0x20 reads the controller lines one clock after they are applied. Internal APB controller k appears at bit k (k = 0, 1), APB expansion controller k at bit 4+k, and AHB expansion controller k at bit 20+k. All other bits read 0.
- R2: A write to 0x28 stores the value ANDed with 0x00F000F3, and 0x28 reads the stored value back. Each controller's enable output equals that controller's bit (the bit position from R1) of the stored word.
- R3: A write to 0x24 loads each controller's clear output with that controller's bit of the registered status word, as it stands at that clock edge. The written data has no effect. Clear outputs hold until the next write to 0x24, and 0x24 reads 0.
- R4: Expansion checker line n appears at bit n+16 of the checker status word at 0x30, one clock after it is applied. Bits 15:0 read 0.
- R5: 0x38 is a full 32-bit read/write enable word. `msc_irq_o` is high exactly when the registered checker status word ANDed with that enable word is nonzero.
- R6: A write to 0x34 sets checker clear line n to bit n+16 of the written data. The lines hold until the next such write, and 0x34 reads 0.
- R7: A write to 0xD0 stores the full word, and 0xD0 reads it back. Checker non-secure line n equals bit n+16 of the stored word.
- R8: The MPC status word at 0x1C shows MPC line n at bit n and expansion MPC line n at bit n+16, one clock after the lines are applied.
- R9: The bridge status word at 0x40 and the bridge clear word at 0x44 always read 0. A write to 0x48 keeps only bits 31:16, and 0x48 reads those bits back.
- R10: Writes to 0x1C, 0x20, 0x30 and 0x40 do not change what those offsets read, and no enable or clear output changes because of such a write. Offsets that are not mapped read 0.
- R11: After reset, every stored word, every readable offset and every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the word at `reg_addr` |
| reg_addr | input | 12 | Word-aligned byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mpc_stat_i | input | NUM_MPC | MPC violation levels |
| mpc_exp_stat_i | input | NUM_EXP_MPC | Expansion MPC violation levels |
| apb_ppc_stat_i | input | 2 | Internal APB controller violation levels |
| apbx_ppc_stat_i | input | 4 | APB expansion controller violation levels |
| ahbx_ppc_stat_i | input | 4 | AHB expansion controller violation levels |
| msc_stat_i | input | NUM_EXP_MSC | Expansion checker violation levels |
| apb_ppc_en_o | output | 2 | Internal APB controller interrupt enables |
| apb_ppc_clr_o | output | 2 | Internal APB controller clear levels |
| apbx_ppc_en_o | output | 4 | APB expansion controller interrupt enables |
| apbx_ppc_clr_o | output | 4 | APB expansion controller clear levels |
| ahbx_ppc_en_o | output | 4 | AHB expansion controller interrupt enables |
| ahbx_ppc_clr_o | output | 4 | AHB expansion controller clear levels |
| msc_clr_o | output | NUM_EXP_MSC | Checker clear levels |
| msc_ns_o | output | NUM_EXP_MSC | Checker non-secure configuration |
| msc_irq_o | output | 1 | Combined checker interrupt |

## Verification
Two functions can land on the same clock edge.

- **Clear write and status change.** A controller clear write can meet a change in the controller status lines. The bench drives a new status pattern in the same cycle as the write to 0x24. It expects each clear output to take the status value registered before that edge, not the new pattern. The new pattern must then show up on the next read of 0x20.
- **Checker status and enable change.** The combined checker interrupt can change because of a status change and an enable write in the same cycle. The bench sweeps every status and enable pairing. It judges the interrupt against the bitwise AND it computes itself.

// File: rtl/sec_irq_hub.sv
module sec_irq_hub #(
  parameter int NUM_MPC     = 4,
  parameter int NUM_EXP_MPC = 4,
  parameter int NUM_EXP_MSC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [11:0]            reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NUM_MPC-1:0]     mpc_stat_i,
  input  logic [NUM_EXP_MPC-1:0] mpc_exp_stat_i,
  input  logic [1:0]             apb_ppc_stat_i,
  input  logic [3:0]             apbx_ppc_stat_i,
  input  logic [3:0]             ahbx_ppc_stat_i,
  input  logic [NUM_EXP_MSC-1:0] msc_stat_i,
  output logic [1:0]             apb_ppc_en_o,
  output logic [1:0]             apb_ppc_clr_o,
  output logic [3:0]             apbx_ppc_en_o,
  output logic [3:0]             apbx_ppc_clr_o,
  output logic [3:0]             ahbx_ppc_en_o,
  output logic [3:0]             ahbx_ppc_clr_o,
  output logic [NUM_EXP_MSC-1:0] msc_clr_o,
  output logic [NUM_EXP_MSC-1:0] msc_ns_o,
  output logic                   msc_irq_o
);
  localparam logic [31:0] PPC_MASK = 32'h00F0_00F3;
  localparam logic [31:0] BRG_MASK = 32'hFFFF_0000;
  localparam logic [11:0] OFS_MPC_ST  = 12'h01C;
  localparam logic [11:0] OFS_PPC_ST  = 12'h020;
  localparam logic [11:0] OFS_PPC_CLR = 12'h024;
  localparam logic [11:0] OFS_PPC_EN  = 12'h028;
  localparam logic [11:0] OFS_MSC_ST  = 12'h030;
  localparam logic [11:0] OFS_MSC_CLR = 12'h034;
  localparam logic [11:0] OFS_MSC_EN  = 12'h038;
  localparam logic [11:0] OFS_BRG_ST  = 12'h040;
  localparam logic [11:0] OFS_BRG_CLR = 12'h044;
  localparam logic [11:0] OFS_BRG_EN  = 12'h048;
  localparam logic [11:0] OFS_MSC_NS  = 12'h0D0;

  logic [31:0] ppc_st_q, ppc_en_q, mpc_st_q, msc_st_q, msc_en_q, msc_ns_q, brg_en_q;
  logic [9:0]  ppc_clr_q;
  logic [NUM_EXP_MSC-1:0] msc_clr_q;

  wire [31:0] ppc_pack = {8'h00, ahbx_ppc_stat_i, 12'h000, apbx_ppc_stat_i, 2'b00, apb_ppc_stat_i};
  wire [31:0] mpc_pack = 32'(mpc_stat_i) | (32'(mpc_exp_stat_i) << 16);
  wire [31:0] msc_pack = 32'(msc_stat_i) << 16;
  wire [9:0]  ppc_st_sel = {ppc_st_q[23:20], ppc_st_q[7:4], ppc_st_q[1:0]};

  wire wr_ppc_clr = reg_wr && reg_addr == OFS_PPC_CLR;
  wire wr_ppc_en  = reg_wr && reg_addr == OFS_PPC_EN;
  wire wr_msc_clr = reg_wr && reg_addr == OFS_MSC_CLR;
  wire wr_msc_en  = reg_wr && reg_addr == OFS_MSC_EN;
  wire wr_msc_ns  = reg_wr && reg_addr == OFS_MSC_NS;
  wire wr_brg_en  = reg_wr && reg_addr == OFS_BRG_EN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppc_st_q  <= '0;
      mpc_st_q  <= '0;
      msc_st_q  <= '0;
      ppc_en_q  <= '0;
      ppc_clr_q <= '0;
      msc_en_q  <= '0;
      msc_ns_q  <= '0;
      msc_clr_q <= '0;
      brg_en_q  <= '0;
    end else begin
      ppc_st_q <= ppc_pack;
      mpc_st_q <= mpc_pack;
      msc_st_q <= msc_pack;
      if (wr_ppc_en)  ppc_en_q  <= reg_wdata & PPC_MASK;
      if (wr_ppc_clr) ppc_clr_q <= ppc_st_sel;
      if (wr_msc_en)  msc_en_q  <= reg_wdata;
      if (wr_msc_ns)  msc_ns_q  <= reg_wdata;
      if (wr_msc_clr) msc_clr_q <= reg_wdata[16 +: NUM_EXP_MSC];
      if (wr_brg_en)  brg_en_q  <= reg_wdata & BRG_MASK;
    end
  end

  assign apb_ppc_en_o   = ppc_en_q[1:0];
  assign apbx_ppc_en_o  = ppc_en_q[7:4];
  assign ahbx_ppc_en_o  = ppc_en_q[23:20];
  assign apb_ppc_clr_o  = ppc_clr_q[1:0];
  assign apbx_ppc_clr_o = ppc_clr_q[5:2];
  assign ahbx_ppc_clr_o = ppc_clr_q[9:6];
  assign msc_clr_o      = msc_clr_q;
  assign msc_ns_o       = msc_ns_q[16 +: NUM_EXP_MSC];
  assign msc_irq_o      = |(msc_st_q & msc_en_q);

  always_comb begin
    case (reg_addr)
      OFS_MPC_ST: reg_rdata = mpc_st_q;
      OFS_PPC_ST: reg_rdata = ppc_st_q;
      OFS_PPC_EN: reg_rdata = ppc_en_q;
      OFS_MSC_ST: reg_rdata = msc_st_q;
      OFS_MSC_EN: reg_rdata = msc_en_q;
      OFS_BRG_EN: reg_rdata = brg_en_q;
      OFS_MSC_NS: reg_rdata = msc_ns_q;
      default:    reg_rdata = 32'h0;
    endcase
  end

  AST_PPC_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ppc_en |=> {ahbx_ppc_en_o, apbx_ppc_en_o, apb_ppc_en_o} ==
                  {$past(reg_wdata[23:20]), $past(reg_wdata[7:4]), $past(reg_wdata[1:0])}); // R2
  AST_PPC_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ppc_clr |=> $stable({ahbx_ppc_clr_o, apbx_ppc_clr_o, apb_ppc_clr_o})); // R3
  AST_MSC_ST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == OFS_MSC_ST |=> msc_st_q[16 +: NUM_EXP_MSC] == $past(msc_stat_i)); // R4
  AST_MSC_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    msc_irq_o |-> msc_en_q[31:16] != 16'h0); // R5
  AST_MSC_NS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msc_ns |=> msc_ns_o == $past(reg_wdata[16 +: NUM_EXP_MSC])); // R7
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == OFS_PPC_CLR || reg_addr == OFS_MSC_CLR || reg_addr == OFS_BRG_CLR |-> reg_rdata == 32'h0); // R9
endmodule

// File: tb/test_sec_irq_hub.sv
module test_sec_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4, NXM = 4, NXS = 4;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NM-1:0]  mpc_stat_i = '0;
  logic [NXM-1:0] mpc_exp_stat_i = '0;
  logic [1:0] apb_ppc_stat_i = '0;
  logic [3:0] apbx_ppc_stat_i = '0, ahbx_ppc_stat_i = '0;
  logic [NXS-1:0] msc_stat_i = '0;
  logic [1:0] apb_ppc_en_o, apb_ppc_clr_o;
  logic [3:0] apbx_ppc_en_o, apbx_ppc_clr_o, ahbx_ppc_en_o, ahbx_ppc_clr_o;
  logic [NXS-1:0] msc_clr_o, msc_ns_o;
  logic msc_irq_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_irq_hub #(.NUM_MPC(NM), .NUM_EXP_MPC(NXM), .NUM_EXP_MSC(NXS)) i_sec_irq_hub (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mpc_stat_i(mpc_stat_i), .mpc_exp_stat_i(mpc_exp_stat_i),
    .apb_ppc_stat_i(apb_ppc_stat_i), .apbx_ppc_stat_i(apbx_ppc_stat_i),
    .ahbx_ppc_stat_i(ahbx_ppc_stat_i), .msc_stat_i(msc_stat_i),
    .apb_ppc_en_o(apb_ppc_en_o), .apb_ppc_clr_o(apb_ppc_clr_o),
    .apbx_ppc_en_o(apbx_ppc_en_o), .apbx_ppc_clr_o(apbx_ppc_clr_o),
    .ahbx_ppc_en_o(ahbx_ppc_en_o), .ahbx_ppc_clr_o(ahbx_ppc_clr_o),
    .msc_clr_o(msc_clr_o), .msc_ns_o(msc_ns_o), .msc_irq_o(msc_irq_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  function automatic logic [31:0] ppc_exp(input logic [9:0] p);
    return (32'(p[1:0])) | (32'(p[5:2]) << 4) | (32'(p[9:6]) << 20);
  endfunction

  function automatic logic [9:0] outs_clr();
    return {ahbx_ppc_clr_o, apbx_ppc_clr_o, apb_ppc_clr_o};
  endfunction

  function automatic logic [9:0] outs_en();
    return {ahbx_ppc_en_o, apbx_ppc_en_o, apb_ppc_en_o};
  endfunction

  task automatic set_ppc(input logic [9:0] p);
    apb_ppc_stat_i = p[1:0]; apbx_ppc_stat_i = p[5:2]; ahbx_ppc_stat_i = p[9:6];
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] e;
    logic [9:0] p, q;
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 256; a += 4) rd_chk(12'(a), 32'h0, "R11 reset read");
    chk({outs_en(), outs_clr(), msc_clr_o, msc_ns_o, msc_irq_o} == '0, "R11 reset outputs",
        32'({outs_en(), outs_clr(), msc_clr_o, msc_ns_o, msc_irq_o}), 32'h0);
    @(negedge clk); rst_n = 1;

    // R1 exhaustive controller status sweep
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk); set_ppc(10'(i));
      @(negedge clk); rd_chk(12'h020, ppc_exp(10'(i)), "R1 ppc status");
    end

    // R8 MPC status sweep
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); mpc_stat_i = 4'(i); mpc_exp_stat_i = 4'(i >> 4);
      @(negedge clk); rd_chk(12'h01C, 32'(i & 15) | (32'(i >> 4) << 16), "R8 mpc status");
    end

    // R2 enable mask, walking ones and patterns
    for (int b = 0; b < 34; b++) begin
      e = (b < 32) ? (32'h1 << b) : (b == 32 ? 32'hFFFF_FFFF : 32'h5A5A_A5A5);
      wr(12'h028, e);
      rd_chk(12'h028, e & 32'h00F0_00F3, "R2 enable readback");
      p = {e[23:20], e[7:4], e[1:0]};
      chk(outs_en() == p, "R2 enable outputs", 32'(outs_en()), 32'(p));
    end

    // R3 clear capture sweep
    for (int i = 0; i < 1024; i += 37) begin
      @(negedge clk); set_ppc(10'(i));
      wr(12'h024, 32'h0);
      chk(outs_clr() == 10'(i), "R3 clear capture", 32'(outs_clr()), 32'(i));
      rd_chk(12'h024, 32'h0, "R3 clear reads zero");
      @(negedge clk); set_ppc(~10'(i));
      repeat (2) @(negedge clk);
      chk(outs_clr() == 10'(i), "R3 clear holds", 32'(outs_clr()), 32'(i));
    end
    // R3 clear write and status change on the same edge
    p = 10'h2A5; q = 10'h15A;
    @(negedge clk); set_ppc(p);
    @(negedge clk); reg_wr = 1; reg_addr = 12'h024; reg_wdata = 32'hFFFF_FFFF; set_ppc(q);
    @(negedge clk); reg_wr = 0;
    chk(outs_clr() == p, "R3 same-edge clear takes old status", 32'(outs_clr()), 32'(p));
    rd_chk(12'h020, ppc_exp(q), "R1 new status after same-edge clear");

    // R4/R5 checker status x enable sweep
    for (int s = 0; s < 16; s++) begin
      for (int en = 0; en < 16; en++) begin
        @(negedge clk); msc_stat_i = 4'(s);
        reg_wr = 1; reg_addr = 12'h038; reg_wdata = (32'(en) << 16) | 32'h0000_FFFF;
        @(negedge clk); reg_wr = 0;
        #1;
        chk(msc_irq_o == ((s & en) != 0), "R5 combined irq", 32'(msc_irq_o), 32'((s & en) != 0));
        if (en == s) begin
          rd_chk(12'h030, 32'(s) << 16, "R4 msc status");
          rd_chk(12'h038, (32'(en) << 16) | 32'h0000_FFFF, "R5 enable readback");
        end
      end
    end

    // R6 checker clear, R7 non-secure
    for (int i = 0; i < 16; i++) begin
      wr(12'h034, (32'(i) << 16) | 32'h0000_BEEF);
      chk(msc_clr_o == 4'(i), "R6 msc clear lines", 32'(msc_clr_o), 32'(i));
      rd_chk(12'h034, 32'h0, "R6 clear reads zero");
      wr(12'h0D0, (32'(15 - i) << 16) | 32'(i));
      chk(msc_ns_o == 4'(15 - i), "R7 msc ns lines", 32'(msc_ns_o), 32'(15 - i));
      rd_chk(12'h0D0, (32'(15 - i) << 16) | 32'(i), "R7 ns readback");
      chk(msc_clr_o == 4'(i), "R6 clear holds", 32'(msc_clr_o), 32'(i));
    end

    // R9 bridge
    wr(12'h048, 32'h1234_5678);
    rd_chk(12'h048, 32'h1234_0000, "R9 bridge enable mask");
    wr(12'h044, 32'hFFFF_FFFF);
    rd_chk(12'h044, 32'h0, "R9 bridge clear reads zero");
    rd_chk(12'h040, 32'h0, "R9 bridge status zero");

    // R10 writes to status words ignored
    @(negedge clk); set_ppc(10'h0F3); mpc_stat_i = 4'h5; mpc_exp_stat_i = 4'hA; msc_stat_i = 4'h9;
    wr(12'h028, 32'h0); wr(12'h024, 32'h0);
    p = outs_clr();
    wr(12'h020, 32'hFFFF_FFFF); rd_chk(12'h020, ppc_exp(10'h0F3), "R10 ppc status write ignored");
    wr(12'h01C, 32'h0); rd_chk(12'h01C, 32'h000A_0005, "R10 mpc status write ignored");
    wr(12'h030, 32'h0); rd_chk(12'h030, 32'h0009_0000, "R10 msc status write ignored");
    wr(12'h040, 32'hFFFF_FFFF); rd_chk(12'h040, 32'h0, "R10 bridge status write ignored");
    chk(outs_en() == 10'h0 && outs_clr() == p, "R10 outputs unchanged",
        32'({outs_en(), outs_clr()}), 32'({10'h0, p}));
    rd_chk(12'h100, 32'h0, "R10 unmapped reads zero");
    rd_chk(12'hFFC, 32'h0, "R10 unmapped reads zero");

    // R11 reset again clears stored state
    @(negedge clk); rst_n = 0; #1;
    rd_chk(12'h0D0, 32'h0, "R11 ns after reset");
    chk(msc_clr_o == '0 && msc_irq_o == 0, "R11 outputs after reset", 32'({msc_clr_o, msc_irq_o}), 32'h0);
    finish_run();
  end
endmodule